// File: doc/BRIEF.md
# Reset Line Active-Pullup Controller

This controller drives the enables around one shared, wired-low reset line. Any device on the line, this one included, can pull the line low. The line has a passive resistive pullup and a faster switched pullup. The analog level detectors report two flags each clock cycle: whether the line is above a low threshold, and whether it is above 85 percent of supply. This controller turns those flags and its own reset request into four outputs: a pulldown enable, a connect enable for the passive pullup, an enable for the switched pullup, and a flag that records that the next line edge will be a rising one.

The switched pullup speeds up the rising edge after a reset so that a processor sampling the line a short time after release sees it high. It may be on only under three conditions. The line must have been seen low since the last rising phase. The line must sit between the two thresholds. Nobody may be holding the line down. A one-shot counter, set in clock cycles, limits how long it stays on. The release sequence does not depend on who pulled the line low. It is the same for this block's own request, whatever the cause behind that request, and for another device on the line. While this block pulls the line low, the passive pullup is cut off so that it draws no current.

Top module: `reset_line_pullup_ctl`

## Requirements
- R1: After the synchronous-logic reset (rstN low), pullDownEn is 0, passiveEn is 1, activeEn is 0 and edgeFlag is 0.
- R2: One clock edge after resetReq is sampled high, pullDownEn is 1 and passiveEn is 0. One clock edge after resetReq is sampled low, pullDownEn is 0 and passiveEn is 1. A line held low by another device leaves passiveEn at 1.
- R3: One clock edge after lineAboveLow is sampled 0, edgeFlag is 1.
- R4: While edgeFlag is 1, if the sampled inputs are lineAboveLow=1, lineAboveHigh=0 and resetReq=0, activeEn is 1 after the next edge.
- R5: While activeEn is 1, sampling lineAboveHigh=1 turns activeEn off and clears edgeFlag at the next edge.
- R6: activeEn stays high for at most ONESHOT_CYCLES consecutive cycles. If the line stays in the window, activeEn falls and edgeFlag clears exactly ONESHOT_CYCLES cycles after activeEn rose.
- R7: While activeEn is 1, sampling lineAboveLow=0 or resetReq=1 turns activeEn off at the next edge with edgeFlag still 1. A later window phase starts a new full one-shot.
- R8: pullDownEn and activeEn are never 1 in the same cycle.
- R9: A line inside the window while edgeFlag is 0 never turns activeEn on.
- R10: While edgeFlag is 1, if the line goes straight from below the low threshold to above the high threshold, edgeFlag clears after one edge and activeEn stays 0.
- R11: While resetReq is 1, activeEn stays 0 even if the level flags report the window. The rising phase starts on the edge at which resetReq is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the controller logic |
| lineAboveLow | input | 1 | Level flag: the line is above the low threshold |
| lineAboveHigh | input | 1 | Level flag: the line is above 85 percent of supply |
| resetReq | input | 1 | This block's own request to pull the line low |
| pullDownEn | output | 1 | Enables the pulldown transistor |
| passiveEn | output | 1 | Connects the passive pullup resistor |
| activeEn | output | 1 | Enables the switched pullup |
| edgeFlag | output | 1 | Set when the next line edge is expected to rise |

## Verification
The rising phase is tried several ways. In one, the line climbs through the window to the high threshold. In another, it stalls in the window until the one-shot runs out. In a third, it drops back below the low threshold in the middle of the phase. In a fourth, it jumps from low to high in one sample. Together these separate the three ways the pullup can end and confirm that a dropped line re-arms the pullup. The same release is also driven with this block's own request and with a line held low from outside. This shows that the pullup waits for the request to drop, and that only the block's own request cuts the passive pullup. A window seen with no prior low level is also applied, which shows that the edge flag, and not the level alone, gates the pullup.

// File: rtl/pullup_ctl_pkg.sv
package pullup_ctl_pkg;

  typedef enum logic [1:0] {
    LINE_IDLE  = 2'd0,
    LINE_ARMED = 2'd1,
    LINE_BOOST = 2'd2
  } lineState_t;

  typedef struct packed {
    logic setEdge;
    logic clearEdge;
    logic startShot;
    logic stopShot;
  } strobes_t;

endpackage

// File: rtl/rlp_control.sv
module rlp_control
  import pullup_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineAboveLow,
  input  logic     lineAboveHigh,
  input  logic     resetReq,
  input  logic     shotDone,
  output strobes_t strobes
);

  lineState_t state, stateNext;
  logic lineHeld;

  assign lineHeld = resetReq || !lineAboveLow;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      LINE_IDLE: begin
        if (!lineAboveLow) begin
          strobes.setEdge = 1'b1;
          stateNext       = LINE_ARMED;
        end
      end
      LINE_ARMED: begin
        if (!lineHeld) begin
          if (lineAboveHigh) begin
            strobes.clearEdge = 1'b1;
            stateNext         = LINE_IDLE;
          end else begin
            strobes.startShot = 1'b1;
            stateNext         = LINE_BOOST;
          end
        end
      end
      LINE_BOOST: begin
        if (lineHeld) begin
          strobes.stopShot = 1'b1;
          stateNext        = LINE_ARMED;
        end else if (lineAboveHigh || shotDone) begin
          strobes.stopShot  = 1'b1;
          strobes.clearEdge = 1'b1;
          stateNext         = LINE_IDLE;
        end
      end
      default: stateNext = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LINE_IDLE;
    else       state <= stateNext;
  end

  AST_START_NOT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startShot |-> (!resetReq && lineAboveLow && !lineAboveHigh)); // R11
  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startShot |-> $past(stateNext) == LINE_ARMED); // R9

endmodule

// File: rtl/rlp_datapath.sv
module rlp_datapath
  import pullup_ctl_pkg::*;
#(
  parameter int ONESHOT_CYCLES = 100
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     resetReq,
  input  strobes_t strobes,
  output logic     shotDone,
  output logic     pullDownEn,
  output logic     passiveEn,
  output logic     activeEn,
  output logic     edgeFlag
);

  localparam int CW = $clog2(ONESHOT_CYCLES + 1);
  localparam logic [CW-1:0] SHOT_LOAD = CW'(ONESHOT_CYCLES);
  localparam logic [CW-1:0] SHOT_LAST = CW'(1);

  logic [CW-1:0] shotCnt;

  assign shotDone = activeEn && (shotCnt == SHOT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullDownEn <= 1'b0;
      passiveEn  <= 1'b1;
    end else begin
      pullDownEn <= resetReq;
      passiveEn  <= !resetReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeEn <= 1'b0;
      shotCnt  <= '0;
    end else if (strobes.startShot) begin
      activeEn <= 1'b1;
      shotCnt  <= SHOT_LOAD;
    end else if (strobes.stopShot) begin
      activeEn <= 1'b0;
      shotCnt  <= '0;
    end else if (activeEn && shotCnt != '0) begin
      shotCnt  <= shotCnt - SHOT_LAST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  edgeFlag <= 1'b0;
    else if (strobes.setEdge)   edgeFlag <= 1'b1;
    else if (strobes.clearEdge) edgeFlag <= 1'b0;
  end

  logic [CW:0] onRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         onRun <= '0;
    else if (activeEn) onRun <= onRun + 1'b1;
    else               onRun <= '0;
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(pullDownEn && activeEn)); // R8
  AST_SHOT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    onRun <= (CW+1)'(ONESHOT_CYCLES)); // R6
  AST_PASSIVE_CUT: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (pullDownEn && !passiveEn)); // R2
  AST_ACTIVE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    activeEn |-> edgeFlag); // R4

endmodule

// File: rtl/reset_line_pullup_ctl.sv
module reset_line_pullup_ctl
  import pullup_ctl_pkg::*;
#(
  parameter int ONESHOT_CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineAboveLow,
  input  logic lineAboveHigh,
  input  logic resetReq,
  output logic pullDownEn,
  output logic passiveEn,
  output logic activeEn,
  output logic edgeFlag
);

  strobes_t strobes;
  logic     shotDone;

  rlp_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .lineAboveLow  (lineAboveLow),
    .lineAboveHigh (lineAboveHigh),
    .resetReq      (resetReq),
    .shotDone      (shotDone),
    .strobes       (strobes)
  );

  rlp_datapath #(.ONESHOT_CYCLES(ONESHOT_CYCLES)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .resetReq   (resetReq),
    .strobes    (strobes),
    .shotDone   (shotDone),
    .pullDownEn (pullDownEn),
    .passiveEn  (passiveEn),
    .activeEn   (activeEn),
    .edgeFlag   (edgeFlag)
  );

  AST_LOW_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (activeEn && !lineAboveLow) |=> (!activeEn && edgeFlag)); // R7
  AST_HIGH_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (activeEn && lineAboveLow && lineAboveHigh && !resetReq) |=> (!activeEn && !edgeFlag)); // R5
  AST_DROP_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    !lineAboveLow |=> edgeFlag); // R3

endmodule

// File: tb/tb_reset_line_pullup_ctl.sv
module tb_reset_line_pullup_ctl;

  localparam int SHOT = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineAboveLow = 1'b1;
  logic lineAboveHigh = 1'b1;
  logic resetReq = 1'b0;
  logic pullDownEn, passiveEn, activeEn, edgeFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_line_pullup_ctl #(.ONESHOT_CYCLES(SHOT)) dut (
    .clk(clk), .rstN(rstN), .lineAboveLow(lineAboveLow),
    .lineAboveHigh(lineAboveHigh), .resetReq(resetReq),
    .pullDownEn(pullDownEn), .passiveEn(passiveEn),
    .activeEn(activeEn), .edgeFlag(edgeFlag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock edge, then an R8 check at the following falling edge
  task automatic step();
    @(negedge clk);
    chk("R8 exclusive enables", pullDownEn && activeEn, 1'b0);
  endtask

  task automatic drive(input logic req, input logic lo, input logic hi);
    resetReq = req; lineAboveLow = lo; lineAboveHigh = hi;
  endtask

  task automatic tReset();
    chk("R1 pullDownEn", pullDownEn, 1'b0);
    chk("R1 passiveEn", passiveEn, 1'b1);
    chk("R1 activeEn", activeEn, 1'b0);
    chk("R1 edgeFlag", edgeFlag, 1'b0);
  endtask

  task automatic tOwnRequest();
    drive(1, 1, 1); step();
    chk("R2 pulldown on", pullDownEn, 1'b1);
    chk("R2 passive cut", passiveEn, 1'b0);
    drive(0, 1, 1); step();
    chk("R2 pulldown off", pullDownEn, 1'b0);
    chk("R2 passive back", passiveEn, 1'b1);
  endtask

  task automatic tNoFlag();
    drive(0, 1, 0); step(); step();
    chk("R9 no flag", edgeFlag, 1'b0);
    chk("R9 no active", activeEn, 1'b0);
    drive(0, 1, 1); step();
  endtask

  task automatic tSkipWindow();
    drive(0, 0, 0); step();
    chk("R3 flag set", edgeFlag, 1'b1);
    drive(0, 1, 1); step();
    chk("R10 flag cleared", edgeFlag, 1'b0);
    chk("R10 no active", activeEn, 1'b0);
  endtask

  task automatic tWindowRise();
    drive(0, 0, 0); step();
    drive(0, 1, 0); step();
    chk("R4 active on", activeEn, 1'b1);
    step();
    chk("R4 active held", activeEn, 1'b1);
    drive(0, 1, 1); step();
    chk("R5 active off", activeEn, 1'b0);
    chk("R5 flag cleared", edgeFlag, 1'b0);
  endtask

  task automatic tOneShot();
    drive(0, 0, 0); step();
    drive(0, 1, 0);
    for (int k = 1; k <= SHOT; k++) begin
      step();
      if (k == 1 || k == SHOT) chk("R6 active during shot", activeEn, 1'b1);
    end
    step();
    chk("R6 shot expired", activeEn, 1'b0);
    chk("R6 flag cleared", edgeFlag, 1'b0);
    drive(0, 1, 1); step();
    chk("R6 stays off", activeEn, 1'b0);
  endtask

  task automatic tInterrupt();
    drive(0, 0, 0); step();
    drive(0, 1, 0); step();
    for (int k = 0; k < 10; k++) step();
    chk("R7 active before drop", activeEn, 1'b1);
    drive(0, 0, 0); step();
    chk("R7 active off on drop", activeEn, 1'b0);
    chk("R7 flag kept", edgeFlag, 1'b1);
    drive(0, 1, 0);
    for (int k = 1; k <= SHOT; k++) begin
      step();
      if (k == SHOT) chk("R7 fresh full shot", activeEn, 1'b1);
    end
    step();
    chk("R7 fresh shot ends", activeEn, 1'b0);
    drive(0, 0, 0); step();
    drive(0, 1, 0); step();
    drive(1, 1, 0); step();
    chk("R7 request stops active", activeEn, 1'b0);
    chk("R7 request keeps flag", edgeFlag, 1'b1);
    drive(0, 1, 1); step();
  endtask

  task automatic tHeldRequest();
    drive(1, 0, 0); step();
    chk("R3 flag on own request", edgeFlag, 1'b1);
    drive(1, 1, 0); step(); step();
    chk("R11 no active under request", activeEn, 1'b0);
    chk("R11 pulldown held", pullDownEn, 1'b1);
    drive(0, 1, 0); step();
    chk("R11 active on release", activeEn, 1'b1);
    chk("R11 pulldown released", pullDownEn, 1'b0);
    drive(0, 1, 1); step();
    chk("R5 off after own release", activeEn, 1'b0);
  endtask

  task automatic tExternalHold();
    drive(0, 0, 0); step(); step(); step();
    chk("R2 passive kept for outside hold", passiveEn, 1'b1);
    chk("R3 flag for outside hold", edgeFlag, 1'b1);
    chk("R7 no active while held", activeEn, 1'b0);
    drive(0, 1, 0); step();
    chk("R4 active after outside release", activeEn, 1'b1);
    drive(0, 1, 1); step();
    chk("R5 off after outside release", edgeFlag, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tOwnRequest();
    tNoFlag();
    tSkipWindow();
    tWindowRise();
    tOneShot();
    tInterrupt();
    tHeldRequest();
    tExternalHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule